// File: doc/BRIEF.md
# Repeated-Addition Sequential Multiplier

This block multiplies an 8-bit unsigned multiplicand by a 4-bit unsigned multiplier and returns a 16-bit product. It does not use an array or shift-and-add scheme. Instead, a controller loads a down-counter with the multiplier. The datapath then adds the multiplicand into an accumulator once per clock until the counter runs out.

The start input is a level that the requester holds high for several cycles. Only its rising edge launches an operation. On that edge both operands are captured. Later changes on the operand inputs therefore have no effect on the result.

When the sum is complete, the done flag rises. The product and the flag then hold until the next accepted start edge.

Top module: `rptmul_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0 and `product` is 0.
- R2: When `done` rises, `product` equals the unsigned product of the multiplicand and multiplier captured at the launching edge. This covers the largest case, 255 × 15 = 3825.
- R3: A rising edge on `start` (a clock where `start` is 1 after being 0 on the previous clock) launches exactly one operation. Keeping `start` high for further cycles does not restart it.
- R4: `done` rises N+1 clock cycles after the clock that samples the start edge, where N is the captured multiplier. The worst case is 16 cycles.
- R5: A multiplier of 0 yields a product of 0, with `done` rising on the cycle after the start edge.
- R6: Once `done` is 1, `done` and `product` keep their values until a start edge is accepted.
- R7: Changes on `mcand` or `mplr` after the start edge do not alter the result.
- R8: A start edge that arrives while an operation is in progress is ignored. The running operation completes with its original operands.
- R9: A start edge accepted while `done` is 1 drives `done` to 0 on the following cycle.
- R10: While an operation is in progress and not finished, `product` grows by exactly the captured multiplicand on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request level; its rising edge launches a multiply |
| mcand | input | 8 | Unsigned multiplicand |
| mplr | input | 4 | Unsigned multiplier (number of additions) |
| product | output | 16 | Accumulator value; the valid product while `done` is 1 |
| done | output | 1 | High when the product is complete, held until the next start edge |

## Verification
Operand pairs are chosen so that different faults give different results. A multiplier of 1 separates an off-by-one in the addition count from a correct count. The 255 × 15 case reveals a truncated accumulator and confirms the longest latency. A multiplier of 0 with a nonzero multiplicand confirms that no addition is made.

Further patterns test the start input and the operand inputs. Holding `start` high for many cycles detects a controller that relaunches on level rather than edge. A second edge pulsed in mid-operation must leave the running count intact. Changing the operand inputs after launch, and again while done, distinguishes captured operands from live ones. A reference model compares `done` and `product` on every clock, so the cycle of each step and the latency are also checked.

// File: rtl/rptmul_pkg.sv
package rptmul_pkg;

    localparam int MCAND_W = 8;
    localparam int MPLR_W  = 4;
    localparam int PROD_W  = MCAND_W + MPLR_W + 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic [MCAND_W-1:0] mcand;
        logic [MPLR_W-1:0]  mplr;
    } mul_operands_t;

    typedef struct packed {
        logic load;
        logic add;
    } mul_ctrl_t;

    function automatic logic [PROD_W-1:0] widen_mcand(input logic [MCAND_W-1:0] v);
        return {{(PROD_W-MCAND_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/rptmul_edge.sv
module rptmul_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/rptmul_ctrl.sv
module rptmul_ctrl
    import rptmul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic [MPLR_W-1:0] mplr_i,
    output mul_ctrl_t         ctrl_o,
    output logic              done_o
);
    mul_state_e        state_q, state_d;
    logic [MPLR_W-1:0] cnt_q;
    logic              accept;
    logic              cnt_zero;

    assign accept   = rise_i && (state_q != ST_BUSY);
    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (accept) state_d = ST_BUSY;
            ST_BUSY:          if (cnt_zero) state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q  <= mplr_i;
                done_o <= 1'b0;
            end else if (state_q == ST_BUSY) begin
                if (cnt_zero) done_o <= 1'b1;
                else          cnt_q  <= cnt_q - 1'b1;
            end
        end
    end

    assign ctrl_o.load = accept;
    assign ctrl_o.add  = (state_q == ST_BUSY) && !cnt_zero;
endmodule

// File: rtl/rptmul_acc.sv
module rptmul_acc
    import rptmul_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  mul_ctrl_t          ctrl_i,
    input  logic [MCAND_W-1:0] mcand_i,
    output logic [PROD_W-1:0]  acc_o
);
    logic [MCAND_W-1:0] mcand_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            acc_o   <= '0;
        end else if (ctrl_i.load) begin
            mcand_q <= mcand_i;
            acc_o   <= '0;
        end else if (ctrl_i.add) begin
            acc_o   <= acc_o + widen_mcand(mcand_q);
        end
    end
endmodule

// File: rtl/rptmul_top.sv
module rptmul_top
    import rptmul_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MCAND_W-1:0] mcand,
    input  logic [MPLR_W-1:0]  mplr,
    output logic [PROD_W-1:0]  product,
    output logic               done
);
    logic          start_rise;
    mul_ctrl_t     ctrl;
    mul_operands_t ops;

    assign ops.mcand = mcand;
    assign ops.mplr  = mplr;

    rptmul_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (start),
        .rise_o  (start_rise)
    );

    rptmul_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .rise_i (start_rise),
        .mplr_i (ops.mplr),
        .ctrl_o (ctrl),
        .done_o (done)
    );

    rptmul_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl),
        .mcand_i (ops.mcand),
        .acc_o   (product)
    );
endmodule

// File: rtl/rptmul_chk.sv
module rptmul_chk
    import rptmul_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [MCAND_W-1:0] mcand,
    input logic [MPLR_W-1:0]  mplr,
    input logic [PROD_W-1:0]  product,
    input logic               done
);
    logic               st_prev;
    logic               op_live;
    logic [MCAND_W-1:0] cap_a;
    logic [MPLR_W-1:0]  cap_b;
    logic [MPLR_W:0]    cyc;
    logic               edge_seen;

    assign edge_seen = start && !st_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_prev <= 1'b0;
            op_live <= 1'b0;
            cap_a   <= '0;
            cap_b   <= '0;
            cyc     <= '0;
        end else begin
            st_prev <= start;
            if (edge_seen && (!op_live || done)) begin
                op_live <= 1'b1;
                cap_a   <= mcand;
                cap_b   <= mplr;
                cyc     <= '0;
            end else if (op_live) begin
                if (done) op_live <= 1'b0;
                else      cyc     <= cyc + 1'b1;
            end
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!done && product == '0)); // R1

    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> product == (widen_mcand(cap_a) * PROD_W'(cap_b))); // R2

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cyc == (MPLR_W+1)'(cap_b) + 1'b1)); // R4

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && !edge_seen) |=> (done && $stable(product))); // R6

    AST_DROP_ON_START: assert property (@(posedge clk) disable iff (rst)
        (done && edge_seen) |=> !done); // R9

    AST_STEP_ADD: assert property (@(posedge clk) disable iff (rst)
        (op_live && !done) |=>
            (done ? $stable(product)
                  : (product == $past(product) + widen_mcand(cap_a)))); // R10
endmodule

bind rptmul_top rptmul_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mcand   (mcand),
    .mplr    (mplr),
    .product (product),
    .done    (done)
);

// File: tb/tb_rptmul_top.sv
`timescale 1ns/1ps
module tb_rptmul_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  mcand = '0;
    logic [3:0]  mplr = '0;
    logic [15:0] product;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference model
    int m_acc = 0, m_a = 0, m_cnt = 0;
    bit m_done = 0, m_busy = 0, m_prev = 0;

    always #5 clk = ~clk;

    rptmul_top dut (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand),
        .mplr(mplr), .product(product), .done(done)
    );

    always @(posedge clk) begin
        bit rise;
        if (rst) begin
            m_prev = 0; m_busy = 0; m_cnt = 0; m_acc = 0; m_done = 0;
        end else begin
            rise   = start && !m_prev;
            m_prev = start;
            if (m_busy) begin
                if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
                else begin m_acc = m_acc + m_a; m_cnt = m_cnt - 1; end
            end else if (rise) begin
                m_a = mcand; m_cnt = mplr; m_acc = 0; m_done = 0; m_busy = 1;
            end
        end
    end

    task automatic cmp(input string tag);
        n_chk++;
        if (done !== m_done) begin
            n_bad++;
            $display("FAIL %s done actual=%b expected=%b t=%0t", tag, done, m_done, $time);
        end
        n_chk++;
        if (product !== 16'(m_acc)) begin
            n_bad++;
            $display("FAIL %s product actual=%0d expected=%0d t=%0t", tag, product, m_acc, $time);
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic run_op(input int a, input int b, input int hold, input string tag);
        mcand = 8'(a); mplr = 4'(b); start = 1'b1;
        repeat (hold) step(tag);
        start = 1'b0;
        repeat (20) step(tag);
    endtask

    initial begin
        repeat (3) step("R1");
        rst = 1'b0;
        repeat (3) step("R1");
        // R2: assorted operand pairs, including the maximum
        run_op(13, 5, 3, "R2");
        run_op(255, 15, 3, "R2");
        run_op(1, 1, 2, "R2");
        run_op(200, 7, 4, "R2");
        // R4: latency checked each cycle against the model
        run_op(9, 12, 2, "R4");
        // R5: zero multiplier
        run_op(77, 0, 3, "R5");
        run_op(0, 9, 3, "R5");
        // R3: start held far beyond the operation length
        mcand = 8'd21; mplr = 4'd4; start = 1'b1;
        repeat (25) step("R3");
        start = 1'b0;
        repeat (5) step("R3");
        // R8: extra edge while busy
        mcand = 8'd50; mplr = 4'd9; start = 1'b1;
        repeat (2) step("R8");
        start = 1'b0; step("R8");
        mcand = 8'd3; mplr = 4'd2;
        start = 1'b1; repeat (2) step("R8");
        start = 1'b0; repeat (15) step("R8");
        // R7: operand changes during busy and done
        mcand = 8'd90; mplr = 4'd6; start = 1'b1;
        repeat (2) step("R7");
        mcand = 8'd255; mplr = 4'd15;
        repeat (2) step("R7");
        start = 1'b0; mcand = 8'd7; mplr = 4'd1;
        repeat (12) step("R7");
        mcand = 8'd128; mplr = 4'd3;
        repeat (4) step("R7");
        // R6: long idle with result held
        repeat (30) step("R6");
        // R9: new edge while done, then R10 stepping
        run_op(17, 8, 2, "R9");
        run_op(33, 10, 2, "R10");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule